// File: doc/BRIEF.md
# Byte-Lane SRAM Access Decoder

This block models the control front end of an asynchronous 16-bit static memory. The storage array is small, and its depth is a parameter. The block decodes the following active-level controls:

- an active-low chip select;
- an active-high second chip select;
- an active-low write strobe;
- an active-low output enable;
- two active-low byte-lane enables.

From these it performs lane-selective writes into the array and lane-selective reads. The tri-state data bus is modelled as a data-out vector plus one output-enable bit per byte lane. A separate flag reports whether the part is in standby or active.

Reads are combinational from the array. This follows the asynchronous nature of the part. A write is committed at the rising clock edge on which the full write condition is seen. Only the enabled lanes take the new data, through a per-lane mask. If both byte enables are inactive, the part drops to standby whatever the chip selects are doing. This is the byte power-down behaviour.

Top module: `sram_lane_ctrl`

## Requirements
- R1: When `ce_n_i` is 1 the block is in standby: `standby_o`=1, `lane_oe_o`=2'b00 and `rdata_o`=0. Writes are also blocked.
- R2: When `ce2_i` is 0 the block is in standby, and a write strobe leaves the array unchanged.
- R3: When `ub_n_i` and `lb_n_i` are both 1, the block is in standby and ignores writes, regardless of both chip selects.
- R4: A read is a cycle where `ce_n_i`=0, `ce2_i`=1, `we_n_i`=1, `oe_n_i`=0 and both byte enables are 0. During a read, `lane_oe_o`=2'b11 and `rdata_o` shows the stored word at `addr_i` in the same cycle.
- R5: `lane_oe_o[1]` follows `ub_n_i` and covers bits 15:8. `lane_oe_o[0]` follows `lb_n_i` and covers bits 7:0. On a byte read only the enabled lane is driven. A lane that is not driven reads as 0 on `rdata_o`.
- R6: With the part selected, `we_n_i`=0 and at least one byte enable low, a write happens at either level of `oe_n_i`. During the write `lane_oe_o`=2'b00, because all lines act as inputs.
- R7: A byte write updates only the enabled lane. The other byte of the stored word keeps its previous value.
- R8: With the part selected, `we_n_i`=1 and `oe_n_i`=1, the outputs are disabled but the part is active: `standby_o`=0 and `lane_oe_o`=2'b00.
- R9: Data is committed at the rising `clk_i` edge on which the write condition holds. A write strobe that is released before the edge stores nothing.
- R10: An active-low `rst_ni` clears every array word to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Commit clock for array writes |
| rst_ni | input | 1 | Asynchronous active-low reset, clears array |
| ce_n_i | input | 1 | Active-low chip select |
| ce2_i | input | 1 | Active-high second chip select |
| we_n_i | input | 1 | Active-low write strobe |
| oe_n_i | input | 1 | Active-low output enable |
| ub_n_i | input | 1 | Active-low upper byte enable (bits 15:8) |
| lb_n_i | input | 1 | Active-low lower byte enable (bits 7:0) |
| addr_i | input | AW (4) | Word address |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data; lanes not driven read 0 |
| lane_oe_o | output | 2 | Per-lane drive enable, bit 1 upper, bit 0 lower |
| standby_o | output | 1 | 1 = standby, 0 = active |

## Verification
A wrong decode shows up at once on `standby_o` and `lane_oe_o`, in the same cycle as the control pattern. For this reason every row of the mode table is compared directly on those ports. A corrupt array word or a wrongly masked lane shows nothing until the next read of that address. The bench therefore reads back every written or guarded address straight after each write, lane attempt and blocked-write attempt.

// File: rtl/sram_lane_pkg.sv
package sram_lane_pkg;
  localparam int unsigned LANE_W = 8;

  typedef enum logic [1:0] {
    MODE_STBY = 2'd0,
    MODE_OFF  = 2'd1,
    MODE_RD   = 2'd2,
    MODE_WR   = 2'd3
  } acc_mode_e;
endpackage

// File: rtl/sram_mode_dec.sv
module sram_mode_dec
  import sram_lane_pkg::*;
#(
  parameter int unsigned LANES   = 2,
  parameter bit          DUAL_CE = 1'b1
) (
  input  logic             ce_n_i,
  input  logic             ce2_i,
  input  logic             we_n_i,
  input  logic             oe_n_i,
  input  logic [LANES-1:0] be_n_i,
  output acc_mode_e        mode_o,
  output logic [LANES-1:0] wmask_o,
  output logic [LANES-1:0] lane_oe_o,
  output logic             standby_o
);
  logic chip_sel;
  logic any_lane;

  generate
    if (DUAL_CE) begin : g_dual
      assign chip_sel = ~ce_n_i & ce2_i;
    end else begin : g_single
      logic unused_ce2;
      assign unused_ce2 = ce2_i;
      assign chip_sel   = ~ce_n_i;
    end
  endgenerate

  // byte power-down: all lanes off forces standby
  assign any_lane = ~&be_n_i;

  always_comb begin
    if (!(chip_sel && any_lane))  mode_o = MODE_STBY;
    else if (!we_n_i)             mode_o = MODE_WR;
    else if (!oe_n_i)             mode_o = MODE_RD;
    else                          mode_o = MODE_OFF;
  end

  assign standby_o = (mode_o == MODE_STBY);
  assign wmask_o   = (mode_o == MODE_WR) ? ~be_n_i : '0;
  assign lane_oe_o = (mode_o == MODE_RD) ? ~be_n_i : '0;
endmodule

// File: rtl/sram_lane_array.sv
module sram_lane_array
  import sram_lane_pkg::*;
#(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned LANES = 2,
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned DW = LANES * LANE_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [LANES-1:0] wmask_i,
  input  logic [AW-1:0]    addr_i,
  input  logic [DW-1:0]    wdata_i,
  output logic [DW-1:0]    rword_o
);
  logic [LANES-1:0][LANE_W-1:0] mem_q [DEPTH];
  logic                         addr_ok;

  assign addr_ok = (32'(addr_i) < DEPTH);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        for (int i = 0; i < DEPTH; i++) mem_q[i][g] <= '0;
      end else if (wmask_i[g] && addr_ok) begin
        mem_q[addr_i][g] <= wdata_i[g*LANE_W +: LANE_W];
      end
    end
    assign rword_o[g*LANE_W +: LANE_W] = addr_ok ? mem_q[addr_i][g] : '0;
  end
endmodule

// File: rtl/sram_out_stage.sv
module sram_out_stage
  import sram_lane_pkg::*;
#(
  parameter int unsigned LANES = 2,
  localparam int unsigned DW = LANES * LANE_W
) (
  input  logic [DW-1:0]    rword_i,
  input  logic [LANES-1:0] lane_oe_i,
  output logic [DW-1:0]    rdata_o
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign rdata_o[g*LANE_W +: LANE_W] =
      lane_oe_i[g] ? rword_i[g*LANE_W +: LANE_W] : '0;
  end
endmodule

// File: rtl/sram_lane_ctrl.sv
module sram_lane_ctrl
  import sram_lane_pkg::*;
#(
  parameter int unsigned DEPTH   = 16,
  parameter bit          DUAL_CE = 1'b1,
  localparam int unsigned LANES = 2,
  localparam int unsigned AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned DW    = LANES * LANE_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ce_n_i,
  input  logic          ce2_i,
  input  logic          we_n_i,
  input  logic          oe_n_i,
  input  logic          ub_n_i,
  input  logic          lb_n_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  output logic [1:0]    lane_oe_o,
  output logic          standby_o
);
  acc_mode_e        mode;
  logic [LANES-1:0] wmask;
  logic [DW-1:0]    rword;
  logic [LANES-1:0] be_n;

  assign be_n = {ub_n_i, lb_n_i};

  sram_mode_dec #(.LANES(LANES), .DUAL_CE(DUAL_CE)) u_dec (
    .ce_n_i   (ce_n_i),
    .ce2_i    (ce2_i),
    .we_n_i   (we_n_i),
    .oe_n_i   (oe_n_i),
    .be_n_i   (be_n),
    .mode_o   (mode),
    .wmask_o  (wmask),
    .lane_oe_o(lane_oe_o),
    .standby_o(standby_o)
  );

  sram_lane_array #(.DEPTH(DEPTH), .LANES(LANES)) u_arr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .wmask_i(wmask),
    .addr_i (addr_i),
    .wdata_i(wdata_i),
    .rword_o(rword)
  );

  sram_out_stage #(.LANES(LANES)) u_out (
    .rword_i  (rword),
    .lane_oe_i(lane_oe_o),
    .rdata_o  (rdata_o)
  );

  logic unused_mode;
  assign unused_mode = ^mode;
endmodule

// File: rtl/sram_lane_ctrl_chk.sv
module sram_lane_ctrl_chk #(
  parameter int unsigned AW = 4,
  parameter int unsigned DW = 16
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          ce_n_i,
  input logic          ce2_i,
  input logic          we_n_i,
  input logic          oe_n_i,
  input logic          ub_n_i,
  input logic          lb_n_i,
  input logic [AW-1:0] addr_i,
  input logic [DW-1:0] rdata_o,
  input logic [1:0]    lane_oe_o,
  input logic          standby_o
);
  // R1
  ce_high_stby_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ce_n_i |-> (standby_o && lane_oe_o == 2'b00));

  // R2
  ce2_low_stby_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ce2_i |-> standby_o);

  // R3
  byte_pdn_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ub_n_i && lb_n_i) |-> (standby_o && lane_oe_o == 2'b00 && rdata_o == '0));

  // R5
  upper_float_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lane_oe_o[1] |-> (rdata_o[DW-1:DW/2] == '0));

  // R5
  lane_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lane_oe_o[1] |-> !ub_n_i) and (lane_oe_o[0] |-> !lb_n_i));

  // R6
  write_no_drive_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!we_n_i) |-> (lane_oe_o == 2'b00));

  // R8
  out_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ce_n_i && ce2_i && we_n_i && oe_n_i && !(ub_n_i && lb_n_i))
      |-> (!standby_o && lane_oe_o == 2'b00));

  // R4
  read_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($stable(addr_i) && we_n_i && $past(we_n_i) && lane_oe_o == 2'b11
       && $past(lane_oe_o) == 2'b11) |-> $stable(rdata_o));
endmodule

bind sram_lane_ctrl sram_lane_ctrl_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .ce_n_i   (ce_n_i),
  .ce2_i    (ce2_i),
  .we_n_i   (we_n_i),
  .oe_n_i   (oe_n_i),
  .ub_n_i   (ub_n_i),
  .lb_n_i   (lb_n_i),
  .addr_i   (addr_i),
  .rdata_o  (rdata_o),
  .lane_oe_o(lane_oe_o),
  .standby_o(standby_o)
);

// File: tb/tb_sram_lane_ctrl.sv
`timescale 1ns/1ps
module tb_sram_lane_ctrl;
  localparam int DEPTH = 16;
  localparam int AW    = 4;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          ce_n_i = 1'b1, ce2_i = 1'b0, we_n_i = 1'b1, oe_n_i = 1'b1;
  logic          ub_n_i = 1'b1, lb_n_i = 1'b1;
  logic [AW-1:0] addr_i = '0;
  logic [15:0]   wdata_i = '0;
  logic [15:0]   rdata_o;
  logic [1:0]    lane_oe_o;
  logic          standby_o;

  int checks = 0;
  int fails  = 0;
  logic [15:0] exp_mem [DEPTH];

  always #10 clk_i = ~clk_i;

  sram_lane_ctrl #(.DEPTH(DEPTH)) dut (.*);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic ce_n, ce2, we_n, oe_n, ub_n, lb_n,
                       input logic [AW-1:0] a, input logic [15:0] d);
    @(negedge clk_i);
    ce_n_i = ce_n; ce2_i = ce2; we_n_i = we_n; oe_n_i = oe_n;
    ub_n_i = ub_n; lb_n_i = lb_n; addr_i = a; wdata_i = d;
    #1;
  endtask

  task automatic idle();
    drive(1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, '0, '0);
  endtask

  // write, commit at next posedge, model update in bench
  task automatic wr(input string tag, input logic oe_n, ub_n, lb_n,
                    input logic [AW-1:0] a, input logic [15:0] d);
    drive(1'b0, 1'b1, 1'b0, oe_n, ub_n, lb_n, a, d);
    chk({tag, " no drive in write"}, {30'd0, lane_oe_o}, 32'd0);
    chk({tag, " active in write"}, {31'd0, standby_o}, 32'd0);
    if (!ub_n) exp_mem[a][15:8] = d[15:8];
    if (!lb_n) exp_mem[a][7:0]  = d[7:0];
    idle();
  endtask

  task automatic rd(input string tag, input logic ub_n, lb_n, input logic [AW-1:0] a);
    logic [15:0] e;
    drive(1'b0, 1'b1, 1'b1, 1'b0, ub_n, lb_n, a, 16'hFFFF);
    e = {(ub_n ? 8'h00 : exp_mem[a][15:8]), (lb_n ? 8'h00 : exp_mem[a][7:0])};
    chk({tag, " rdata"}, {16'd0, rdata_o}, {16'd0, e});
    chk({tag, " lane_oe"}, {30'd0, lane_oe_o}, {30'd0, ~ub_n, ~lb_n});
    idle();
  endtask

  task automatic t_reset();
    for (int i = 0; i < DEPTH; i++) exp_mem[i] = '0;
    chk("R1 reset standby", {31'd0, standby_o}, 32'd1);
    chk("R1 reset lane_oe", {30'd0, lane_oe_o}, 32'd0);
    chk("R1 reset rdata", {16'd0, rdata_o}, 32'd0);
    for (int i = 0; i < DEPTH; i += 5) rd("R10 cleared word", 1'b0, 1'b0, AW'(i));
  endtask

  task automatic t_full_words();
    wr("R6 oe high", 1'b1, 1'b0, 1'b0, 4'd1, 16'hA5C3);
    wr("R6 oe low", 1'b0, 1'b0, 1'b0, 4'd2, 16'h1234);
    wr("R6 top addr", 1'b1, 1'b0, 1'b0, 4'd15, 16'hFFFF);
    rd("R4 word 1", 1'b0, 1'b0, 4'd1);
    rd("R4 word 2", 1'b0, 1'b0, 4'd2);
    rd("R4 word 15", 1'b0, 1'b0, 4'd15);
  endtask

  task automatic t_lanes();
    wr("R7 low lane", 1'b1, 1'b1, 1'b0, 4'd1, 16'h77EE);
    wr("R7 high lane", 1'b0, 1'b0, 1'b1, 4'd2, 16'h9900);
    rd("R7 word 1 after low", 1'b0, 1'b0, 4'd1);
    rd("R7 word 2 after high", 1'b0, 1'b0, 4'd2);
    rd("R5 low byte read", 1'b1, 1'b0, 4'd1);
    rd("R5 high byte read", 1'b0, 1'b1, 4'd2);
  endtask

  task automatic t_blocked();
    drive(1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 4'd1, 16'hDEAD);
    chk("R1 ce_n high standby", {31'd0, standby_o}, 32'd1);
    idle();
    drive(1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 4'd1, 16'hBEEF);
    chk("R2 ce2 low standby", {31'd0, standby_o}, 32'd1);
    idle();
    drive(1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 4'd1, 16'hCAFE);
    chk("R3 byte power-down standby", {31'd0, standby_o}, 32'd1);
    idle();
    drive(1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 4'd1, 16'h0);
    chk("R3 read blocked lane_oe", {30'd0, lane_oe_o}, 32'd0);
    chk("R3 read blocked rdata", {16'd0, rdata_o}, 32'd0);
    idle();
    drive(1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 4'd1, 16'h0);
    chk("R1 read deselected lane_oe", {30'd0, lane_oe_o}, 32'd0);
    idle();
    rd("R1 R2 R3 word 1 unchanged", 1'b0, 1'b0, 4'd1);
  endtask

  task automatic t_out_off();
    drive(1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 4'd2, 16'h0);
    chk("R8 active", {31'd0, standby_o}, 32'd0);
    chk("R8 lane_oe", {30'd0, lane_oe_o}, 32'd0);
    chk("R8 rdata", {16'd0, rdata_o}, 32'd0);
    drive(1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 4'd2, 16'h0);
    chk("R8 low lane only lane_oe", {30'd0, lane_oe_o}, 32'd0);
    idle();
  endtask

  task automatic t_strobe_edge();
    drive(1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 4'd3, 16'h5A5A);
    #4 we_n_i = 1'b1;  // released before the posedge
    idle();
    rd("R9 released strobe no commit", 1'b0, 1'b0, 4'd3);
    wr("R9 held strobe", 1'b1, 1'b0, 1'b0, 4'd3, 16'h6B6B);
    rd("R9 held strobe commits", 1'b0, 1'b0, 4'd3);
  endtask

  initial begin
    #1;
    repeat (2) @(posedge clk_i);
    #3 rst_ni = 1'b1;
    #1;
    t_reset();
    t_full_words();
    t_lanes();
    t_blocked();
    t_out_off();
    t_strobe_edge();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #200000;
    checks++;
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule